// File: doc/BRIEF.md
# Temperature Sensor Register Target

This block is the register side of a digital temperature sensor on a two-wire management bus. The serial bit engine sits elsewhere. It delivers each finished transaction to this block as one strobe with a kind code, a 7-bit target address, a command byte and up to 16 data bits. The block answers in the same cycle: acknowledge, a success flag and read data. Any register change takes effect at the next clock edge.

Eight byte registers sit behind a pointer. They are a temperature pair loaded from an external reading at reset, a configuration byte, a hysteresis limit pair, an over-temperature limit pair and a spare slot. Word transactions reach whole pairs. Byte transactions reach single registers. A companion device can claim the upper half of the command space: when its forwarding address is set, byte accesses with codes of 0x80 and above leave through a forwarding port, and its read reply is returned combinationally.

Top module: `temp_reg_slave`

## Requirements
- R1: Kind codes are 0 send byte, 1 write byte, 2 write word, 3 receive byte, 4 read byte and 5 read word. Codes 6 and 7 get no acknowledge. A transaction is acknowledged only when `bus_id` is nonzero and equals `tx_addr`. Without acknowledge, `rx_ok` is 0, `rx_data` is 0, nothing is forwarded and no state changes.
- R2: After reset, register 0 holds `temp_c` and register 1 holds 0 (the reading shifted left by eight). Register 3 holds 0x4B, register 5 holds 0x50, and registers 2, 4, 6 and 7 and the pointer are zero.
- R3: A byte write targets the register given by command bits [2:0]. Registers 0, 1 and 7 keep their value and `rx_ok` is 0. Any other register stores `tx_data[7:0]` and `rx_ok` is 1.
- R4: A byte read returns the register given by command bits [2:0] in `rx_data[7:0]`, with the upper byte 0. Reads, send and receive report `rx_ok` = 1. Writes and send return data 0.
- R5: A send byte loads the pointer with `tx_data[7:0]`. A receive byte returns the register given by pointer bits [2:0].
- R6: A word read selects a pair by command bits [1:0]: 0 gives (0,1), 1 gives (2,2), 2 gives (3,4) and 3 gives (5,6). The first register goes to `rx_data[7:0]` and the second to `rx_data[15:8]`.
- R7: A word write uses the same pair selection. `tx_data[15:8]` goes to the first register and `tx_data[7:0]` to the second. For selection 1, only `tx_data[7:0]` reaches register 2. Selection 0 changes nothing and gives `rx_ok` = 0.
- R8: When `fwd_id` is nonzero, a byte read, byte write or receive whose code (the command, or the pointer for receive) is 0x80 or more is forwarded. `fw_req` rises with `fw_code`, `fw_we` and `fw_wdata`. A read returns `{8'h00, fw_rdata}`, `rx_ok` is 1 and the local registers are untouched. When `fwd_id` is zero, such codes alias onto the local registers by their low bits.
- R9: Word transactions are never forwarded, whatever their command code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_id | input | 7 | Own bus address, zero disables the target |
| fwd_id | input | 7 | Companion address, nonzero enables forwarding |
| temp_c | input | 8 | Temperature reading sampled at reset |
| tx_vld | input | 1 | Transaction strobe |
| tx_kind | input | 3 | Transaction kind code |
| tx_addr | input | 7 | Transaction target address |
| tx_cmd | input | 8 | Command byte |
| tx_data | input | 16 | Write data |
| rx_ack | output | 1 | Transaction acknowledged |
| rx_ok | output | 1 | Transaction succeeded |
| rx_data | output | 16 | Read data |
| fw_req | output | 1 | Forwarded access strobe |
| fw_we | output | 1 | Forwarded access is a write |
| fw_code | output | 8 | Forwarded register code |
| fw_wdata | output | 8 | Forwarded write byte |
| fw_rdata | input | 8 | Forwarded read reply |

## Verification
Word reads are run against pairs holding different high and low bytes, so a missing byte swap or a wrong pair mapping shows at once. Byte writes are aimed at both writable and read-only slots and then read back. This separates a dropped store from a store that should have been refused. High command codes are applied with forwarding on and off, and with word kinds, to separate forwarding from aliasing. Address mismatches, a zero own address and a reset with a new temperature reading cover the acknowledge rule and the defaults.

// File: rtl/temp_reg_slave.sv
module temp_reg_slave #(
  parameter int          ADDR_W   = 7,
  parameter int          NREG     = 8,
  parameter logic [7:0]  HYST_RST = 8'h4B,
  parameter logic [7:0]  OVT_RST  = 8'h50,
  parameter logic [7:0]  FWD_BASE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_id,
  input  logic [ADDR_W-1:0] fwd_id,
  input  logic [7:0]        temp_c,
  input  logic              tx_vld,
  input  logic [2:0]        tx_kind,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [7:0]        tx_cmd,
  input  logic [15:0]       tx_data,
  output logic              rx_ack,
  output logic              rx_ok,
  output logic [15:0]       rx_data,
  output logic              fw_req,
  output logic              fw_we,
  output logic [7:0]        fw_code,
  output logic [7:0]        fw_wdata,
  input  logic [7:0]        fw_rdata
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [2:0] K_SEND = 3'd0, K_WRB = 3'd1, K_WRW = 3'd2,
                         K_RECV = 3'd3, K_RDB = 3'd4, K_RDW = 3'd5;
  localparam logic [IDX_W-1:0] T_HI = IDX_W'(0), T_LO = IDX_W'(1), CFG = IDX_W'(2),
                               HY_HI = IDX_W'(3), HY_LO = IDX_W'(4),
                               OV_HI = IDX_W'(5), OV_LO = IDX_W'(6),
                               SPARE = IDX_W'(NREG-1);

  logic [7:0] regs [NREG];
  logic [7:0] ptr;

  function automatic logic writable(input logic [IDX_W-1:0] i);
    return (i != T_HI) && (i != T_LO) && (i != SPARE);
  endfunction

  wire hit     = tx_vld && (bus_id != '0) && (tx_addr == bus_id);
  wire is_send = (tx_kind == K_SEND);
  wire is_wrb  = (tx_kind == K_WRB);
  wire is_wrw  = (tx_kind == K_WRW);
  wire is_recv = (tx_kind == K_RECV);
  wire is_rdb  = (tx_kind == K_RDB);
  wire is_rdw  = (tx_kind == K_RDW);
  wire known   = tx_kind <= K_RDW;

  wire [7:0]       code = is_recv ? ptr : tx_cmd;
  wire [IDX_W-1:0] bidx = code[IDX_W-1:0];
  wire             fwd  = hit && (fwd_id != '0) && (is_wrb || is_rdb || is_recv)
                          && (code >= FWD_BASE);

  logic [IDX_W-1:0] fa, sa;
  always_comb begin
    case (tx_cmd[1:0])
      2'd0:    begin fa = T_HI;  sa = T_LO;  end
      2'd1:    begin fa = CFG;   sa = CFG;   end
      2'd2:    begin fa = HY_HI; sa = HY_LO; end
      default: begin fa = OV_HI; sa = OV_LO; end
    endcase
  end

  logic             wa_en, wb_en;
  logic [IDX_W-1:0] wa_idx;
  logic [7:0]       wa_dat;
  always_comb begin
    wa_en  = 1'b0;
    wb_en  = 1'b0;
    wa_idx = bidx;
    wa_dat = tx_data[7:0];
    if (hit && is_wrb && !fwd)
      wa_en = writable(bidx);
    if (hit && is_wrw) begin
      if (tx_cmd[1:0] == 2'd1) begin
        wa_en  = 1'b1;
        wa_idx = CFG;
      end else begin
        wa_en  = writable(fa);
        wa_idx = fa;
        wa_dat = tx_data[15:8];
        wb_en  = writable(sa);
      end
    end
  end

  assign rx_ack = hit && known;
  assign rx_ok  = rx_ack && (is_send || is_recv || is_rdb || is_rdw || fwd || wa_en);

  always_comb begin
    rx_data = '0;
    if (hit) begin
      if (is_rdb || is_recv)
        rx_data = {8'h00, fwd ? fw_rdata : regs[bidx]};
      else if (is_rdw)
        rx_data = {regs[sa], regs[fa]};
    end
  end

  assign fw_req   = fwd;
  assign fw_we    = fwd && is_wrb;
  assign fw_code  = fwd ? code : 8'h00;
  assign fw_wdata = (fwd && is_wrb) ? tx_data[7:0] : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
      regs[T_HI]  <= temp_c;
      regs[HY_HI] <= HYST_RST;
      regs[OV_HI] <= OVT_RST;
      ptr         <= 8'h00;
    end else begin
      if (wa_en) regs[wa_idx] <= wa_dat;
      if (wb_en) regs[sa]     <= tx_data[7:0];
      if (hit && is_send) ptr <= tx_data[7:0];
    end
  end

  // R1: an unacknowledged cycle is silent on every output
  p_nack_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !rx_ack |-> (rx_data == 16'h0000) && !rx_ok && !fw_req);

  // R3: temperature bytes only change through reset
  p_temp_ro_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(regs[T_HI]) && $stable(regs[T_LO]));

  // R3: an accepted local byte write lands in its slot
  p_byte_store_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && is_wrb && rx_ok && !fw_req) |=> regs[$past(bidx)] == $past(tx_data[7:0]));

  // R5: send byte reloads the pointer
  p_ptr_load_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_ack && is_send) |=> ptr == $past(tx_data[7:0]));

  // R8: forwarding only for high codes with a companion present
  p_fwd_high_r8: assert property (@(posedge clk) disable iff (rst)
    fw_req |-> (fw_code >= FWD_BASE) && (fwd_id != '0) && rx_ack);

  // R9: word kinds never reach the forwarding port
  p_word_local_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && (is_rdw || is_wrw)) |-> !fw_req);
endmodule

// File: tb/temp_reg_slave_bench.sv
`timescale 1ns/1ps
module temp_reg_slave_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  bus_id = 7'h48;
  logic [6:0]  fwd_id = 7'h2D;
  logic [7:0]  temp_c = 8'h1E;
  logic        tx_vld = 1'b0;
  logic [2:0]  tx_kind = 3'd0;
  logic [6:0]  tx_addr = 7'h00;
  logic [7:0]  tx_cmd = 8'h00;
  logic [15:0] tx_data = 16'h0000;
  logic        rx_ack, rx_ok, fw_req, fw_we;
  logic [15:0] rx_data;
  logic [7:0]  fw_code, fw_wdata;
  logic [7:0]  fw_rdata = 8'hA5;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  temp_reg_slave u_temp_reg_slave (
    .clk(clk), .rst(rst), .bus_id(bus_id), .fwd_id(fwd_id), .temp_c(temp_c),
    .tx_vld(tx_vld), .tx_kind(tx_kind), .tx_addr(tx_addr), .tx_cmd(tx_cmd),
    .tx_data(tx_data), .rx_ack(rx_ack), .rx_ok(rx_ok), .rx_data(rx_data),
    .fw_req(fw_req), .fw_we(fw_we), .fw_code(fw_code), .fw_wdata(fw_wdata),
    .fw_rdata(fw_rdata)
  );

  // req[55:52] kind[51:49] addr[48:42] cmd[41:34] data[33:18] ack[17] ok[16] exp[15:0]
  localparam int NV = 32;
  localparam logic [55:0] VEC [NV] = '{
    {4'd2, 3'd5, 7'h48, 8'h00, 16'h0000, 1'b1, 1'b1, 16'h001E}, // R2 temp pair
    {4'd2, 3'd5, 7'h48, 8'h02, 16'h0000, 1'b1, 1'b1, 16'h004B}, // R2 hysteresis
    {4'd2, 3'd5, 7'h48, 8'h03, 16'h0000, 1'b1, 1'b1, 16'h0050}, // R2 over-temp
    {4'd4, 3'd4, 7'h48, 8'h00, 16'h0000, 1'b1, 1'b1, 16'h001E}, // R4
    {4'd5, 3'd3, 7'h48, 8'h00, 16'h0000, 1'b1, 1'b1, 16'h001E}, // R5 pointer 0
    {4'd3, 3'd1, 7'h48, 8'h02, 16'h0011, 1'b1, 1'b1, 16'h0000}, // R3 cfg write
    {4'd6, 3'd5, 7'h48, 8'h01, 16'h0000, 1'b1, 1'b1, 16'h1111}, // R6 cfg twice
    {4'd3, 3'd1, 7'h48, 8'h00, 16'h0077, 1'b1, 1'b0, 16'h0000}, // R3 ro reg 0
    {4'd3, 3'd4, 7'h48, 8'h00, 16'h0000, 1'b1, 1'b1, 16'h001E}, // R3 kept
    {4'd3, 3'd1, 7'h48, 8'h07, 16'h0099, 1'b1, 1'b0, 16'h0000}, // R3 ro reg 7
    {4'd3, 3'd4, 7'h48, 8'h07, 16'h0000, 1'b1, 1'b1, 16'h0000}, // R3 kept
    {4'd7, 3'd2, 7'h48, 8'h02, 16'h1234, 1'b1, 1'b1, 16'h0000}, // R7 hyst word
    {4'd6, 3'd5, 7'h48, 8'h02, 16'h0000, 1'b1, 1'b1, 16'h3412}, // R6 swap
    {4'd7, 3'd4, 7'h48, 8'h03, 16'h0000, 1'b1, 1'b1, 16'h0012}, // R7 first gets high
    {4'd7, 3'd4, 7'h48, 8'h04, 16'h0000, 1'b1, 1'b1, 16'h0034}, // R7 second gets low
    {4'd7, 3'd2, 7'h48, 8'h01, 16'hABCD, 1'b1, 1'b1, 16'h0000}, // R7 cfg word
    {4'd7, 3'd4, 7'h48, 8'h02, 16'h0000, 1'b1, 1'b1, 16'h00CD}, // R7 low byte only
    {4'd7, 3'd2, 7'h48, 8'h00, 16'h5566, 1'b1, 1'b0, 16'h0000}, // R7 temp word refused
    {4'd7, 3'd5, 7'h48, 8'h00, 16'h0000, 1'b1, 1'b1, 16'h001E}, // R7 kept
    {4'd9, 3'd2, 7'h48, 8'h87, 16'h6070, 1'b1, 1'b1, 16'h0000}, // R9 high word write local
    {4'd9, 3'd5, 7'h48, 8'h03, 16'h0000, 1'b1, 1'b1, 16'h7060}, // R9
    {4'd5, 3'd0, 7'h48, 8'h00, 16'h0005, 1'b1, 1'b1, 16'h0000}, // R5 send
    {4'd5, 3'd3, 7'h48, 8'h00, 16'h0000, 1'b1, 1'b1, 16'h0060}, // R5 receive
    {4'd4, 3'd4, 7'h48, 8'h0D, 16'h0000, 1'b1, 1'b1, 16'h0060}, // R4 low bits index
    {4'd1, 3'd5, 7'h49, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R1 mismatch read
    {4'd1, 3'd1, 7'h49, 8'h03, 16'h00EE, 1'b0, 1'b0, 16'h0000}, // R1 mismatch write
    {4'd1, 3'd4, 7'h48, 8'h03, 16'h0000, 1'b1, 1'b1, 16'h0012}, // R1 untouched
    {4'd1, 3'd6, 7'h48, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R1 bad kind
    {4'd8, 3'd4, 7'h48, 8'h85, 16'h0000, 1'b1, 1'b1, 16'h00A5}, // R8 forwarded read
    {4'd8, 3'd1, 7'h48, 8'h83, 16'h0044, 1'b1, 1'b1, 16'h0000}, // R8 forwarded write
    {4'd8, 3'd4, 7'h48, 8'h03, 16'h0000, 1'b1, 1'b1, 16'h0012}, // R8 local untouched
    {4'd9, 3'd5, 7'h48, 8'h83, 16'h0000, 1'b1, 1'b1, 16'h7060}  // R9 high word read local
  };

  task automatic chk(input int req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic txn(input logic [2:0] k, input logic [6:0] a, input logic [7:0] c,
                     input logic [15:0] d);
    @(negedge clk);
    tx_vld = 1'b1; tx_kind = k; tx_addr = a; tx_cmd = c; tx_data = d;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      txn(VEC[i][51:49], VEC[i][48:42], VEC[i][41:34], VEC[i][33:18]);
      chk(int'(VEC[i][55:52]), $sformatf("vec %0d ack", i), 32'(rx_ack), 32'(VEC[i][17]));
      chk(int'(VEC[i][55:52]), $sformatf("vec %0d ok", i), 32'(rx_ok), 32'(VEC[i][16]));
      chk(int'(VEC[i][55:52]), $sformatf("vec %0d data", i), 32'(rx_data), 32'(VEC[i][15:0]));
    end

    // R8 forwarding port contents on a write
    txn(3'd1, 7'h48, 8'h83, 16'h0044);
    chk(8, "fwd write strobe", {fw_req, fw_we}, 32'h3);
    chk(8, "fwd write code", 32'(fw_code), 32'h83);
    chk(8, "fwd write data", 32'(fw_wdata), 32'h44);
    // R8 receive through a high pointer
    txn(3'd0, 7'h48, 8'h00, 16'h0090);
    txn(3'd3, 7'h48, 8'h00, 16'h0000);
    chk(8, "fwd recv data", 32'(rx_data), 32'h00A5);
    chk(8, "fwd recv code", {fw_req, fw_we, fw_code}, {22'h0, 2'b10, 8'h90});

    // R8 forwarding disabled: high code aliases locally
    @(negedge clk) fwd_id = 7'h00;
    txn(3'd1, 7'h48, 8'h84, 16'h0021);
    chk(8, "alias write no fwd", {fw_req, rx_ok}, 32'h1);
    txn(3'd4, 7'h48, 8'h04, 16'h0000);
    chk(8, "alias write landed", 32'(rx_data), 32'h0021);
    @(negedge clk) fwd_id = 7'h2D;

    // R1 zero own address never answers
    @(negedge clk) bus_id = 7'h00;
    txn(3'd5, 7'h00, 8'h00, 16'h0000);
    chk(1, "zero id ack", {rx_ack, rx_data}, 32'h0);
    @(negedge clk) bus_id = 7'h48;

    // R2 reset with a new reading
    @(negedge clk) begin tx_vld = 1'b0; temp_c = 8'h2D; rst = 1'b1; end
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    txn(3'd5, 7'h48, 8'h00, 16'h0000);
    chk(2, "reset temp pair", 32'(rx_data), 32'h002D);
    txn(3'd5, 7'h48, 8'h01, 16'h0000);
    chk(2, "reset cfg", 32'(rx_data), 32'h0000);
    txn(3'd5, 7'h48, 8'h02, 16'h0000);
    chk(2, "reset hyst", 32'(rx_data), 32'h004B);
    txn(3'd5, 7'h48, 8'h03, 16'h0000);
    chk(2, "reset ovt", 32'(rx_data), 32'h0050);
    txn(3'd4, 7'h48, 8'h07, 16'h0000);
    chk(2, "reset spare", 32'(rx_data), 32'h0000);
    txn(3'd3, 7'h48, 8'h00, 16'h0000);
    chk(2, "reset pointer", 32'(rx_data), 32'h002D);
    @(negedge clk) tx_vld = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule